// File: doc/BRIEF.md
# Register-Tunneled I2C DAC Writer

This block performs one write-only I2C transaction to a voltage-setting DAC without owning any I2C pins. The I2C clock and data lines exist only as two bits inside a power-control register of a panel controller. Each change of those lines is therefore a complete register write. Every register write leaves the block as an 8-bit frame over a valid/ready handshake. A downstream serializer carries the frames to the controller.

The caller pulses `start_i` with the DAC value and the three power-enable bits that have to stay put while the DAC is programmed. The block then emits 87 frames: a start condition, the device byte, the command byte, the value byte with an unsampled acknowledge slot after each byte, and a stop condition. It keeps a fixed idle gap of `GAP_NS` nanoseconds between consecutive frames. It holds `busy_o` for the whole transaction and pulses `done_o` once the last frame has been taken.

Top module: `dac_tunnel_writer`

## Requirements
- R1: Every frame carries `REG_ADDR` (default 0) in bits 7:5, the power-enable bits captured at the accepted start in bits 4:2, the I2C data level in bit 1 and the I2C clock level in bit 0.
- R2: The first three frames form a start condition: clock and data both high, then clock high with data low, then both low.
- R3: Each transferred bit takes three frames: clock low with the data level, the same data with clock high, then clock low again with the same data.
- R4: Three bytes follow the start in this order: `DEV_BYTE` (0x9C), `CMD_BYTE` (0x00), then the captured value. Each byte is sent most significant bit first.
- R5: After each byte comes one extra bit slot with data held low, clocked like any other bit. The block never samples an acknowledge.
- R6: The last three frames form a stop condition: both low, then clock high with data low, then clock and data both high.
- R7: After each accepted frame except the last, `frame_valid_o` stays low for exactly GAP_CYC = CLK_HZ*GAP_NS/1e9 clock cycles before the next frame is offered.
- R8: While `frame_valid_o` is high and `frame_ready_i` is low, the frame stays unchanged and the sequence does not advance.
- R9: `done_o` is high for exactly one cycle, in the cycle after the 87th frame is accepted. `busy_o` is high from the cycle after an accepted start until that cycle, and is low while `done_o` is high.
- R10: A `start_i` pulse while `busy_o` is high is ignored. The frames of the running transaction keep the value and enable bits that were captured when it started.
- R11: After reset, `frame_valid_o`, `busy_o` and `done_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start request, taken only while idle |
| value_i | input | 8 | DAC value byte |
| keep_i | input | 3 | Power-enable bits copied into every frame |
| frame_o | output | 8 | Register write frame {address, payload} |
| frame_valid_o | output | 1 | Frame offered |
| frame_ready_i | input | 1 | Frame taken by the serializer |
| busy_o | output | 1 | Transaction in progress |
| done_o | output | 1 | One-cycle pulse at the end of a transaction |

## Verification
A wrong phase, step or bit counter shows up as a wrong clock or data bit in the very next frame offered, so the bench compares every frame against a sequence it computes itself. A gap counter that is off by one changes how long valid stays low after an acceptance, and a wrong count is visible on the first frame that follows. A sequencer that ends early or late moves `done_o` away from the cycle after the 87th acceptance. If a start pulse leaks through while busy, the value byte or the enable bits of the running transaction change.

// File: rtl/dac_tunnel_writer.sv
module dac_tunnel_writer #(
  parameter int          CLK_HZ   = 200_000_000,
  parameter int          GAP_NS   = 10_000,
  parameter logic [2:0]  REG_ADDR = 3'd0,
  parameter logic [7:0]  DEV_BYTE = 8'h9C,
  parameter logic [7:0]  CMD_BYTE = 8'h00
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start_i,
  input  logic [7:0] value_i,
  input  logic [2:0] keep_i,
  output logic [7:0] frame_o,
  output logic       frame_valid_o,
  input  logic       frame_ready_i,
  output logic       busy_o,
  output logic       done_o
);
  localparam longint GAP_RAW = (longint'(CLK_HZ) * longint'(GAP_NS)) / 64'd1_000_000_000;
  localparam int     GAP_CYC = (GAP_RAW < 1) ? 1 : int'(GAP_RAW);
  localparam int     CW      = $clog2(GAP_CYC + 1);

  typedef enum logic [1:0] {S_IDLE, S_SEND, S_GAP} state_t;
  typedef enum logic [1:0] {P_START, P_BITS, P_STOP} phase_t;

  state_t      state;
  phase_t      phase;
  logic [1:0]  step;
  logic [3:0]  bit_idx;
  logic [1:0]  byte_idx;
  logic [CW-1:0] gap_cnt;
  logic [7:0]  val_q;
  logic [2:0]  keep_q;
  logic [7:0]  cur_byte;
  logic [2:0]  sel;
  logic        bit_lvl, scl, sda, last, accept;

  assign cur_byte = (byte_idx == 2'd0) ? DEV_BYTE : (byte_idx == 2'd1) ? CMD_BYTE : val_q;
  assign sel      = 3'd7 - bit_idx[2:0];
  assign bit_lvl  = !bit_idx[3] && cur_byte[sel];

  always_comb begin
    unique case (phase)
      P_START: begin scl = (step != 2'd2); sda = (step == 2'd0); end
      P_STOP:  begin scl = (step != 2'd0); sda = (step == 2'd2); end
      default: begin scl = (step == 2'd1); sda = bit_lvl;       end
    endcase
  end

  assign frame_o       = {REG_ADDR, keep_q, sda, scl};
  assign frame_valid_o = (state == S_SEND);
  assign busy_o        = (state != S_IDLE);
  assign accept        = frame_valid_o && frame_ready_i;
  assign last          = (phase == P_STOP) && (step == 2'd2);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= S_IDLE;
      phase    <= P_START;
      step     <= '0;
      bit_idx  <= '0;
      byte_idx <= '0;
      gap_cnt  <= '0;
      val_q    <= '0;
      keep_q   <= '0;
      done_o   <= 1'b0;
    end else begin
      done_o <= 1'b0;
      unique case (state)
        S_IDLE: if (start_i) begin
          val_q    <= value_i;
          keep_q   <= keep_i;
          phase    <= P_START;
          step     <= '0;
          bit_idx  <= '0;
          byte_idx <= '0;
          state    <= S_SEND;
        end
        S_SEND: if (accept) begin
          if (last) begin
            state  <= S_IDLE;
            done_o <= 1'b1;
          end else begin
            state   <= S_GAP;
            gap_cnt <= '0;
            if (step != 2'd2) begin
              step <= step + 2'd1;
            end else begin
              step <= '0;
              if (phase == P_START) begin
                phase <= P_BITS;
              end else if (bit_idx == 4'd8) begin
                bit_idx <= '0;
                if (byte_idx == 2'd2) phase <= P_STOP;
                else                  byte_idx <= byte_idx + 2'd1;
              end else begin
                bit_idx <= bit_idx + 4'd1;
              end
            end
          end
        end
        S_GAP: begin
          if (gap_cnt == CW'(GAP_CYC - 1)) state <= S_SEND;
          else                              gap_cnt <= gap_cnt + 1'b1;
        end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/dac_tunnel_writer_chk.sv
module dac_tunnel_writer_chk #(
  parameter int         GAP_CYC  = 1,
  parameter logic [2:0] REG_ADDR = 3'd0
) (
  input logic       clk,
  input logic       rst_n,
  input logic       start_i,
  input logic [2:0] keep_i,
  input logic [7:0] frame_o,
  input logic       frame_valid_o,
  input logic       frame_ready_i,
  input logic       busy_o,
  input logic       done_o
);
  logic [6:0] nfr;
  logic [2:0] keep_cap;
  logic       pend;
  int         gcnt;
  logic       acc;
  assign acc = frame_valid_o && frame_ready_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      nfr <= '0; keep_cap <= '0; pend <= 1'b0; gcnt <= 0;
    end else begin
      if (start_i && !busy_o) keep_cap <= keep_i;
      if (acc) nfr <= (nfr == 7'd86) ? 7'd0 : nfr + 7'd1;
      if (acc && nfr != 7'd86) begin pend <= 1'b1; gcnt <= 0; end
      else if (frame_valid_o)  pend <= 1'b0;
      else if (pend)           gcnt <= gcnt + 1;
    end
  end

  AST_ADDR_FIELD: assert property (@(posedge clk) disable iff (!rst_n)
    frame_valid_o |-> frame_o[7:5] == REG_ADDR); // R1
  AST_KEEP_FIELD: assert property (@(posedge clk) disable iff (!rst_n)
    frame_valid_o |-> frame_o[4:2] == keep_cap); // R1
  AST_HOLD_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    frame_valid_o && !frame_ready_i |=> frame_valid_o && $stable(frame_o)); // R8
  AST_GAP_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    acc && nfr != 7'd86 |=> !frame_valid_o); // R7
  AST_GAP_LEN: assert property (@(posedge clk) disable iff (!rst_n)
    frame_valid_o && pend |-> gcnt == GAP_CYC); // R7
  AST_DONE_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o); // R9
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !busy_o && !frame_valid_o); // R9
  AST_DONE_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> $past(acc && nfr == 7'd86)); // R9
  AST_BUSY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o && !(acc && nfr == 7'd86) |=> busy_o); // R10
endmodule

bind dac_tunnel_writer dac_tunnel_writer_chk #(.GAP_CYC(GAP_CYC), .REG_ADDR(REG_ADDR)) u_chk (
  .clk(clk), .rst_n(rst_n), .start_i(start_i), .keep_i(keep_i), .frame_o(frame_o),
  .frame_valid_o(frame_valid_o), .frame_ready_i(frame_ready_i), .busy_o(busy_o), .done_o(done_o));

// File: tb/sim_dac_tunnel_writer.sv
module sim_dac_tunnel_writer;
  localparam int GAP = 20;
  logic clk = 1'b0, rst_n = 1'b0, start_i = 1'b0, frame_ready_i = 1'b0;
  logic [7:0] value_i = '0;
  logic [2:0] keep_i = '0;
  logic [7:0] frame_o;
  logic frame_valid_o, busy_o, done_o;
  int checks = 0, errors = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  dac_tunnel_writer #(.CLK_HZ(200_000_000), .GAP_NS(100)) u0 (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .value_i(value_i), .keep_i(keep_i),
    .frame_o(frame_o), .frame_valid_o(frame_valid_o), .frame_ready_i(frame_ready_i),
    .busy_o(busy_o), .done_o(done_o));

  // {value, keep, stall, poke_while_busy}
  localparam logic [12:0] VEC [4] = '{
    {8'h7D, 3'b101, 1'b0, 1'b0},
    {8'h00, 3'b000, 1'b1, 1'b0},
    {8'hFF, 3'b111, 1'b0, 1'b1},
    {8'hA5, 3'b010, 1'b1, 1'b1}
  };

  function automatic logic [7:0] exp_frame(logic [7:0] v, logic [2:0] kp, int n);
    logic c, d;
    if (n < 3) begin c = (n != 2); d = (n == 0); end
    else if (n >= 84) begin c = (n != 84); d = (n == 86); end
    else begin
      int k = (n - 3) / 3, t = (n - 3) % 3, by = k / 9, b = k % 9;
      logic [7:0] bv = (by == 0) ? 8'h9C : (by == 1) ? 8'h00 : v;
      c = (t == 1);
      d = (b == 8) ? 1'b0 : bv[7 - b];
    end
    return {3'b000, kp, d, c};
  endfunction

  function automatic string req_of(int n);
    if (n < 3) return "R2";
    if (n >= 84) return "R6";
    if (((n - 3) / 3) % 9 == 8) return "R5";
    return "R3/R4";
  endfunction

  task automatic check(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic run_txn(logic [7:0] v, logic [2:0] kp, bit stall, bit poke);
    int idx = 0, hold = 0, low = 0, guard = 0;
    @(negedge clk);
    value_i = v; keep_i = kp; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0; value_i = ~v; keep_i = ~kp;
    check(busy_o, "R9", "busy after start", busy_o, 1);
    while (idx < 87 && guard < 20000) begin
      guard++;
      start_i = 1'b0;
      if (poke && idx == 10 && !frame_valid_o) start_i = 1'b1;
      if (frame_valid_o) begin
        if (idx > 0 && hold == 0) check(low == GAP, "R7", "gap length", low, GAP);
        check(frame_o == exp_frame(v, kp, idx), req_of(idx), $sformatf("frame %0d", idx),
              frame_o, exp_frame(v, kp, idx));
        check(frame_o[7:2] == {3'b000, kp}, "R1", "addr/keep field", frame_o[7:2], {3'b000, kp});
        if (stall && hold < 2) begin
          frame_ready_i = 1'b0; hold++;
        end else begin
          frame_ready_i = 1'b1; hold = 0; idx++; low = 0;
        end
      end else begin
        frame_ready_i = 1'b0;
        low++;
      end
      @(negedge clk);
    end
    start_i = 1'b0;
    frame_ready_i = 1'b0;
    check(done_o == 1'b1, "R9", "done after last accept", done_o, 1);
    check(busy_o == 1'b0, "R9", "idle at done", busy_o, 0);
    @(negedge clk);
    check(done_o == 1'b0, "R9", "done one cycle", done_o, 0);
    repeat (GAP + 3) begin
      @(negedge clk);
      if (poke) check(!busy_o && !frame_valid_o, "R10", "no restart from poke", busy_o, 0);
    end
  endtask

  initial begin
    #1;
    check(!frame_valid_o && !busy_o && !done_o, "R11", "reset outputs",
          {frame_valid_o, busy_o, done_o}, 0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(!frame_valid_o && !busy_o && !done_o, "R11", "idle after reset",
          {frame_valid_o, busy_o, done_o}, 0);
    for (int i = 0; i < 4; i++)
      run_txn(VEC[i][12:5], VEC[i][4:2], VEC[i][1], VEC[i][0]);
    // R8: a frame left unaccepted for a long time stays put
    @(negedge clk);
    value_i = 8'h3C; keep_i = 3'b011; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    repeat (10) begin
      @(negedge clk);
      check(frame_valid_o && frame_o == exp_frame(8'h3C, 3'b011, 0), "R8", "stalled frame",
            frame_o, exp_frame(8'h3C, 3'b011, 0));
    end
    // R11: reset in mid-transaction clears outputs
    rst_n = 1'b0;
    #1;
    check(!frame_valid_o && !busy_o && !done_o, "R11", "reset mid-run",
          {frame_valid_o, busy_o, done_o}, 0);
    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule